// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers event pulses from two serial peripherals into one request flag per source and decides when to ask the CPU for a subroutine call to an interrupt vector. The first source is a synchronous serial interface with three events. The second is an asynchronous receiver/transmitter with six events. Each source has its own enable bit and its own flag. A single global enable gates both sources. A call is requested only when the processor's return stack has room.

The controller is a two-state machine. In `ST_IDLE` it watches the pending condition. On the transition `IDLE_TO_REQ` it latches the winning source and raises the vector request. In `ST_REQ` it holds the request and the vector index steady. On the transition `REQ_TO_IDLE`, taken when the CPU accepts, it clears the global enable and the flag of the serviced source. Software reads and writes the global enable, the source enables and the flags through a small register port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the global enable, both source enables and both flags read 0, `vec_req` is 0 and the machine is in `ST_IDLE`.
- R2: A pulse on any bit of `ser_evt` (bit 0 byte done, bit 1 address match, bit 2 bus time-out) sets the serial flag (flag register bit 0) at the next clock edge.
- R3: A pulse on any bit of `uart_evt` (bits 0 to 5: transmit empty, transmitter idle, receive ready, overrun, address detect, wake-up) sets the UART flag (flag register bit 1) at the next clock edge.
- R4: In `ST_IDLE`, `vec_req` rises one cycle after a cycle in which the global enable is set, some source has both its enable and its flag set, and `stack_full` is 0. Otherwise it stays 0.
- R5: When both sources are pending, the serial source wins. `vec_idx` is 0 for the serial source and 1 for the UART source.
- R6: In `ST_REQ`, `vec_req` stays 1 and `vec_idx` stays stable until `vec_ack` is seen high at a clock edge.
- R7: At the edge where `vec_ack` is accepted, the global enable is cleared.
- R8: At the same edge, the serviced source's flag is cleared and the other flag is left unchanged.
- R9: An event that arrives in the acceptance cycle keeps the serviced flag set.
- R10: Register map on `reg_addr`: 0 holds the global enable in bit 0, 1 holds the source enables, 2 holds the flags. A write takes effect at the next edge. Writing 1 sets a bit and writing 0 clears it. `reg_rdata` shows the addressed register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_evt | input | 3 | Serial-interface event pulses |
| uart_evt | input | 6 | UART event pulses |
| stack_full | input | 1 | Return stack has no free entry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Register read data |
| vec_ack | input | 1 | CPU accepts the vector request |
| vec_req | output | 1 | Vector call request |
| vec_idx | output | 1 | Index of the requested vector |

## Verification
Several properties are checked on every cycle by the assertions:
- a request never starts without the global enable, a pending enabled source and a free stack;
- a waiting request keeps its index;
- the serial source wins a tie;
- an event always leaves its flag set;
- an acceptance clears the global enable and the serviced flag.

Other behaviour only the bench's scenarios can show. This covers the mapping of each individual event bit onto the correct flag, the register layout and read-back, and the exact cycle in which the request appears after the stack frees up. It also covers the sequence in which the UART request follows once the serial one has been serviced and the global enable is written back.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
    localparam int NSRC   = 2;
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int ADDR_W = 2;
    localparam int REG_W  = NSRC;

    localparam logic [ADDR_W-1:0] ADR_GIE  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } arb_state_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic             en_we,
    input  logic             en_wd,
    input  logic             flg_we,
    input  logic             flg_wd,
    input  logic             clr,
    output logic             en,
    output logic             flag
);
    logic hit;
    assign hit = |evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (en_we) en <= en_wd;
            // an arriving event beats both the write and the auto-clear
            if (hit)         flag <= 1'b1;
            else if (flg_we) flag <= flg_wd;
            else if (clr)    flag <= 1'b0;
        end
    end

    // R9 and R2/R3: any event leaves the flag set
    a_r9_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R8: a service clear with no competing event or write empties the flag
    a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit && !flg_we) |=> !flag);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import vec_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gie,
    input  logic [NSRC-1:0]  pend,
    input  logic             stack_full,
    input  logic             vec_ack,
    output logic             vec_req,
    output logic [IDX_W-1:0] vec_idx,
    output logic [NSRC-1:0]  svc_clr
);
    arb_state_t       state, state_nx;
    logic [IDX_W-1:0] idx_q, win;
    logic             go;

    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (pend[i]) win = IDX_W'(i);
    end

    assign go = gie && (|pend) && !stack_full;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go)      state_nx = ST_REQ;   // IDLE_TO_REQ
            ST_REQ:  if (vec_ack) state_nx = ST_IDLE;  // REQ_TO_IDLE
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && go) idx_q <= win;
        end
    end

    always_comb begin
        vec_req = 1'b0;
        svc_clr = '0;
        unique case (state)
            ST_IDLE: vec_req = 1'b0;
            ST_REQ: begin
                vec_req = 1'b1;
                if (vec_ack) svc_clr[idx_q] = 1'b1;
            end
            default: vec_req = 1'b0;
        endcase
    end
    assign vec_idx = idx_q;

    // R4: a request only starts from a fully enabled pending source with stack room
    a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> $past(gie && (|pend) && !stack_full));
    // R6: a waiting request is held with a stable index
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_ack) |=> (vec_req && $stable(vec_idx)));
    // R5: the serial source wins whenever it was pending
    a_r5_prio: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_req) && $past(pend[0])) |-> (vec_idx == '0));
    // R8: at most one flag is cleared per service
    a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_clr));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vec_irq_pkg::*;
#(
    parameter int SER_EVT_W  = 3,
    parameter int UART_EVT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SER_EVT_W-1:0]  ser_evt,
    input  logic [UART_EVT_W-1:0] uart_evt,
    input  logic                  stack_full,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  vec_ack,
    output logic                  vec_req,
    output logic [IDX_W-1:0]      vec_idx
);
    logic            gie;
    logic [NSRC-1:0] en, flag, svc_clr;
    logic            we_gie, we_en, we_flag;
    logic            unused_wd;

    assign we_gie    = reg_we && (reg_addr == ADR_GIE);
    assign we_en     = reg_we && (reg_addr == ADR_EN);
    assign we_flag   = reg_we && (reg_addr == ADR_FLAG);
    assign unused_wd = ^reg_wdata[REG_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gie <= 1'b0;
        else if (we_gie)   gie <= reg_wdata[0];
        else if (|svc_clr) gie <= 1'b0;
    end

    irq_src_cell #(.EVT_W(SER_EVT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .evt(ser_evt),
        .en_we(we_en), .en_wd(reg_wdata[0]),
        .flg_we(we_flag), .flg_wd(reg_wdata[0]),
        .clr(svc_clr[0]), .en(en[0]), .flag(flag[0]));

    irq_src_cell #(.EVT_W(UART_EVT_W)) u_uart (
        .clk(clk), .rst_n(rst_n), .evt(uart_evt),
        .en_we(we_en), .en_wd(reg_wdata[1]),
        .flg_we(we_flag), .flg_wd(reg_wdata[1]),
        .clr(svc_clr[1]), .en(en[1]), .flag(flag[1]));

    irq_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .gie(gie), .pend(en & flag),
        .stack_full(stack_full), .vec_ack(vec_ack),
        .vec_req(vec_req), .vec_idx(vec_idx), .svc_clr(svc_clr));

    always_comb begin
        unique case (reg_addr)
            ADR_GIE:  reg_rdata = {{(REG_W-1){1'b0}}, gie};
            ADR_EN:   reg_rdata = en;
            ADR_FLAG: reg_rdata = flag;
            default:  reg_rdata = '0;
        endcase
    end

    // R7: an accepted service drops the global enable unless software rewrites it
    a_r7_gie_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack && !we_gie) |=> !gie);
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] ser_evt = '0;
    logic [5:0] uart_evt = '0;
    logic       stack_full = 0;
    logic       reg_we = 0;
    logic [1:0] reg_addr = '0;
    logic [1:0] reg_wdata = '0;
    logic [1:0] reg_rdata;
    logic       vec_ack = 0;
    logic       vec_req;
    logic [0:0] vec_idx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vec_irq_ctrl uut (.*);

    // {ser_evt, uart_evt, expected flags}
    localparam logic [10:0] VECS [10] = '{
        {3'b001, 6'b000000, 2'b01},
        {3'b010, 6'b000000, 2'b01},
        {3'b100, 6'b000000, 2'b01},
        {3'b000, 6'b000001, 2'b10},
        {3'b000, 6'b000010, 2'b10},
        {3'b000, 6'b000100, 2'b10},
        {3'b000, 6'b001000, 2'b10},
        {3'b000, 6'b010000, 2'b10},
        {3'b000, 6'b100000, 2'b10},
        {3'b111, 6'b111111, 2'b11}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    logic [1:0] v;

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 gie", 8'(v), 8'h0);
        rd(2'd1, v); check("R1 en", 8'(v), 8'h0);
        rd(2'd2, v); check("R1 flag", 8'(v), 8'h0);
        check("R1 vec_req", 8'(vec_req), 8'h0);
        rst_n = 1;

        // R2/R3 event table, enables off so no request
        for (int i = 0; i < 10; i++) begin
            wr(2'd2, 2'b00);
            ser_evt = VECS[i][10:8]; uart_evt = VECS[i][7:2];
            @(negedge clk);
            ser_evt = '0; uart_evt = '0;
            rd(2'd2, v);
            check(VECS[i][1:0] == 2'b10 ? "R3 uart flag" : "R2 serial flag", 8'(v), 8'(VECS[i][1:0]));
        end

        // R10 writes: set and clear
        wr(2'd2, 2'b00); rd(2'd2, v); check("R10 flag clear", 8'(v), 8'h0);
        wr(2'd1, 2'b11); rd(2'd1, v); check("R10 en set", 8'(v), 8'h3);
        wr(2'd2, 2'b11); rd(2'd2, v); check("R10 flag set", 8'(v), 8'h3);

        // R4 gating: gie off
        repeat (2) @(negedge clk);
        check("R4 no req gie=0", 8'(vec_req), 8'h0);
        stack_full = 1;
        wr(2'd0, 2'b01);
        repeat (2) @(negedge clk);
        check("R4 no req stack full", 8'(vec_req), 8'h0);
        stack_full = 0;
        @(negedge clk);
        check("R4 req after stack frees", 8'(vec_req), 8'h1);
        check("R5 serial wins", 8'(vec_idx), 8'h0);

        // R6 hold
        stack_full = 1;
        repeat (3) @(negedge clk);
        check("R6 req held", 8'(vec_req), 8'h1);
        check("R6 idx held", 8'(vec_idx), 8'h0);
        stack_full = 0;

        // R7/R8 acceptance
        vec_ack = 1;
        @(negedge clk);
        vec_ack = 0;
        check("R7 req dropped", 8'(vec_req), 8'h0);
        rd(2'd0, v); check("R7 gie cleared", 8'(v), 8'h0);
        rd(2'd2, v); check("R8 serial flag only", 8'(v), 8'h2);

        // R5 uart follows after gie rewrite
        wr(2'd0, 2'b01);
        @(negedge clk);
        check("R5 uart req", 8'(vec_req), 8'h1);
        check("R5 uart idx", 8'(vec_idx), 8'h1);

        // R9 event in acceptance cycle
        vec_ack = 1; uart_evt = 6'b000100;
        @(negedge clk);
        vec_ack = 0; uart_evt = '0;
        rd(2'd2, v); check("R9 flag kept", 8'(v), 8'h2);
        rd(2'd0, v); check("R7 gie cleared uart", 8'(v), 8'h0);
        @(negedge clk);
        check("R4 no req after service", 8'(vec_req), 8'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule